// File: doc/BRIEF.md
# Boot Image Shadowing Sequencer

This block runs once after power-up and stands between a block-storage reader, the DRAM and the processor's reset pin. The processor is held in reset the whole time. The block first programs the DRAM controller from a small built-in table of register writes. It then reads a boot image from a ready/valid word stream and checks the image header. It writes the image payload into DRAM at DRAM's native base. It then issues one write to the system remap register, so that DRAM appears at address zero. Only after that does it let the processor out of reset. The processor's first fetch therefore finds the image's vector table, with the stack pointer at offset 0 and the reset handler at offset 4.

A mode input chosen at start-up selects programming instead of booting. In that mode the block releases the processor at once and touches neither DRAM nor storage, so firmware can load the storage device. Any handshake that stays unanswered too long, or a header that does not mark a valid image, puts the block into a sticky fault. In fault the processor stays in reset for good.

Top module: `boot_shadow_seq`

## Requirements
- R1: While reset is applied, and in the first cycles after it, `cpu_rst_n_o` is 0, `status_o` is 0 (idle), and `done_o`, `err_o`, `cfg_req_o`, `mem_req_o` and `img_ready_o` are all 0.
- R2: In boot mode the block first issues 8 configuration writes in order. Entry i (0..7) writes data 0x1000_0000 + 17*i to address 0x4002_0000 + 8*i. No stream word is accepted before the eighth write is acknowledged.
- R3: A write request (configuration or memory) stays asserted with stable address and data until its acknowledge. Only one request is active at a time. `img_ready_o` is 0 while a memory write is outstanding.
- R4: After the header, payload word n (counting from 0) is written to DRAM address 0xA000_0000 + 4*n with its stream value unchanged. Header words are never written to DRAM, and exactly the stated number of payload words is written.
- R5: Stream word 0 must equal 0xB007_1A9E. Stream word 1 gives the payload length in 32-bit words. A length of 0 skips the copy and goes straight to remap. After a good boot, DRAM offset 0 holds the first payload word and offset 4 the second.
- R6: The remap step is exactly one configuration write of data 0x0000_0001 to address 0x4003_8008. It is issued only after the last payload write is acknowledged.
- R7: `cpu_rst_n_o` rises only after the remap acknowledge (or directly from idle in programming mode) and then stays 1. `done_o` is 1 for exactly the first cycle in which `cpu_rst_n_o` is 1.
- R8: If `prog_mode_i` is 1 when the block leaves idle, it releases the processor without any configuration, memory or stream transfer.
- R9: A first stream word other than the constant puts the block into fault. No remap and no DRAM write follow. `err_o` is 1, `cpu_rst_n_o` stays 0, and all requests and `img_ready_o` stay 0 from then on, whatever the inputs do.
- R10: If a request goes 1024 cycles without an acknowledge, the block enters the same sticky fault. This applies during init, copy and remap.
- R11: `status_o` encodes 0 idle, 1 DRAM init, 2 header and copy, 3 remap, 4 processor released, 5 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_mode_i | input | 1 | 1 selects storage programming, 0 selects boot from DRAM |
| cfg_req_o | output | 1 | Configuration register write request |
| cfg_addr_o | output | 32 | Configuration write address |
| cfg_data_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Configuration write acknowledge |
| mem_req_o | output | 1 | DRAM word write request |
| mem_addr_o | output | 32 | DRAM write byte address |
| mem_data_o | output | 32 | DRAM write data |
| mem_ack_i | input | 1 | DRAM write acknowledge |
| img_valid_i | input | 1 | Image stream word valid |
| img_data_i | input | 32 | Image stream word |
| img_ready_o | output | 1 | Image stream ready |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| done_o | output | 1 | One-cycle pulse when the processor is released |
| err_o | output | 1 | Sticky fault flag |
| status_o | output | 3 | Sequencer phase code |

## Verification
The bench runs images of several lengths: a short one, an empty one and a long one. It feeds them with gaps in the stream and random acknowledge delays, so the start of the copy, the stream back-pressure and the remap trigger are each exercised against different timings. A bad header separates the validity check from the copy path. Withholding a single acknowledge in turn during init, copy and remap shows that the timeout covers every phase and that the fault holds. A run in programming mode shows that the release path bypasses all transfers.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    STS_IDLE  = 3'd0,
    STS_INIT  = 3'd1,
    STS_COPY  = 3'd2,
    STS_REMAP = 3'd3,
    STS_RUN   = 3'd4,
    STS_FAULT = 3'd5
  } bss_status_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_INIT,
    FS_MAGIC,
    FS_LEN,
    FS_COPY,
    FS_REMAP,
    FS_RUN,
    FS_FAULT
  } bss_fsm_e;

endpackage

// File: rtl/bss_init_rom.sv
// Fixed table of DRAM controller setup writes, generated from the index.
module bss_init_rom #(
  parameter int                  ADDR_W    = 32,
  parameter int                  DATA_W    = 32,
  parameter int                  ENTRIES   = 8,
  parameter logic [ADDR_W-1:0]   CTRL_BASE = 32'h4002_0000,
  parameter logic [DATA_W-1:0]   DATA_SEED = 32'h1000_0000,
  localparam int                 IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic [ADDR_W-1:0] tbl_addr [ENTRIES];
  logic [DATA_W-1:0] tbl_data [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign tbl_addr[g] = CTRL_BASE + ADDR_W'(g * 8);
    assign tbl_data[g] = DATA_SEED + DATA_W'(g * 17);
  end

  assign addr_o = tbl_addr[idx_i];
  assign data_o = tbl_data[idx_i];

endmodule

// File: rtl/bss_ack_timer.sv
// Counts cycles a request waits unanswered; flags expiry on the last one.
module bss_ack_timer #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  input  logic ack_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stalled;

  assign stalled   = wait_i && !ack_i;
  assign expired_o = stalled && (cnt_q == CNT_W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (stalled) cnt_d = cnt_q + 1'b1;
    else         cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bss_copy_path.sv
// Holds image length, payload index and the word awaiting its DRAM write.
module bss_copy_path #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] DRAM_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_len_i,
  input  logic [DATA_W-1:0] len_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              wr_done_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);

  logic [DATA_W-1:0] len_q, len_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              pend_q, pend_d;
  logic              len_en, cnt_en, word_en, pend_en;

  assign len_en  = load_len_i;
  assign word_en = take_i && !pend_q;
  assign cnt_en  = load_len_i || (wr_done_i && pend_q);
  assign pend_en = word_en || (wr_done_i && pend_q);

  always_comb begin
    len_d  = len_i;
    word_d = word_i;
    cnt_d  = load_len_i ? '0 : cnt_q + 1'b1;
    pend_d = word_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (len_en)  len_q  <= len_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (word_en) word_q <= word_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign data_o = word_q;
  assign addr_o = DRAM_BASE + ADDR_W'({cnt_q, 2'b00});
  assign last_o = (cnt_q == len_q - 1'b1);

endmodule

// File: rtl/boot_shadow_seq.sv
module boot_shadow_seq
  import bss_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter int                INIT_ENTRIES = 8,
  parameter int                ACK_LIMIT    = 1024,
  parameter logic [ADDR_W-1:0] DRAM_BASE    = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] CTRL_BASE    = 32'h4002_0000,
  parameter logic [DATA_W-1:0] INIT_SEED    = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] REMAP_ADDR   = 32'h4003_8008,
  parameter logic [DATA_W-1:0] REMAP_DATA   = 32'h0000_0001,
  parameter logic [DATA_W-1:0] IMG_MAGIC    = 32'hB007_1A9E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode_i,
  output logic              cfg_req_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_data_o,
  input  logic              cfg_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  input  logic              img_valid_i,
  input  logic [DATA_W-1:0] img_data_i,
  output logic              img_ready_o,
  output logic              cpu_rst_n_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        status_o
);

  localparam int IDX_W = (INIT_ENTRIES > 1) ? $clog2(INIT_ENTRIES) : 1;

  // reset synchroniser: async assert, sync release
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  bss_fsm_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic              rel_seen_q, rel_seen_d;

  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              tmo;
  logic              cfg_hs, mem_hs, img_hs;
  logic              cp_pend, cp_last;
  logic              load_len;

  bss_init_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(INIT_ENTRIES),
    .CTRL_BASE(CTRL_BASE), .DATA_SEED(INIT_SEED)
  ) u_rom (
    .idx_i(idx_q), .addr_o(rom_addr), .data_o(rom_data)
  );

  bss_ack_timer #(.LIMIT(ACK_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rs_q),
    .wait_i(cfg_req_o || mem_req_o),
    .ack_i(cfg_hs || mem_hs),
    .expired_o(tmo)
  );

  bss_copy_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DRAM_BASE(DRAM_BASE)
  ) u_cp (
    .clk(clk), .rst_n(rs_q),
    .load_len_i(load_len), .len_i(img_data_i),
    .take_i(img_hs && st_q == FS_COPY), .word_i(img_data_i),
    .wr_done_i(mem_hs),
    .pend_o(cp_pend), .addr_o(mem_addr_o), .data_o(mem_data_o),
    .last_o(cp_last)
  );

  // handshake and port decode
  assign cfg_req_o   = (st_q == FS_INIT) || (st_q == FS_REMAP);
  assign cfg_addr_o  = (st_q == FS_REMAP) ? REMAP_ADDR : rom_addr;
  assign cfg_data_o  = (st_q == FS_REMAP) ? REMAP_DATA : rom_data;
  assign mem_req_o   = (st_q == FS_COPY) && cp_pend;
  assign img_ready_o = (st_q == FS_MAGIC) || (st_q == FS_LEN) ||
                       ((st_q == FS_COPY) && !cp_pend);
  assign cfg_hs      = cfg_req_o && cfg_ack_i;
  assign mem_hs      = mem_req_o && mem_ack_i;
  assign img_hs      = img_ready_o && img_valid_i;
  assign load_len    = (st_q == FS_LEN) && img_valid_i;

  assign cpu_rst_n_o = (st_q == FS_RUN);
  assign done_o      = (st_q == FS_RUN) && !rel_seen_q;
  assign err_o       = (st_q == FS_FAULT);

  always_comb begin
    unique case (st_q)
      FS_IDLE:                     status_o = STS_IDLE;
      FS_INIT:                     status_o = STS_INIT;
      FS_MAGIC, FS_LEN, FS_COPY:   status_o = STS_COPY;
      FS_REMAP:                    status_o = STS_REMAP;
      FS_RUN:                      status_o = STS_RUN;
      default:                     status_o = STS_FAULT;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d       = st_q;
    idx_en     = 1'b0;
    idx_d      = idx_q + 1'b1;
    rel_seen_d = rel_seen_q | (st_q == FS_RUN);
    unique case (st_q)
      FS_IDLE:  st_d = prog_mode_i ? FS_RUN : FS_INIT;
      FS_INIT: begin
        if (tmo) st_d = FS_FAULT;
        else if (cfg_hs) begin
          idx_en = 1'b1;
          if (idx_q == IDX_W'(INIT_ENTRIES - 1)) st_d = FS_MAGIC;
        end
      end
      FS_MAGIC: begin
        if (img_valid_i) st_d = (img_data_i == IMG_MAGIC) ? FS_LEN : FS_FAULT;
      end
      FS_LEN: begin
        if (img_valid_i) st_d = (img_data_i == '0) ? FS_REMAP : FS_COPY;
      end
      FS_COPY: begin
        if (tmo) st_d = FS_FAULT;
        else if (mem_hs && cp_last) st_d = FS_REMAP;
      end
      FS_REMAP: begin
        if (tmo) st_d = FS_FAULT;
        else if (cfg_hs) st_d = FS_RUN;
      end
      FS_RUN:   st_d = FS_RUN;
      default:  st_d = FS_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      st_q       <= FS_IDLE;
      idx_q      <= '0;
      rel_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      rel_seen_q <= rel_seen_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/bss_checker.sv
module bss_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_req_o,
  input logic [31:0] cfg_addr_o,
  input logic [31:0] cfg_data_o,
  input logic        cfg_ack_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_data_o,
  input logic        mem_ack_i,
  input logic        img_ready_o,
  input logic        cpu_rst_n_o,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  status_o
);

  // R3: one request at a time
  a_r3_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req_o && mem_req_o));

  // R3: no stream acceptance while a DRAM write waits
  a_r3_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !img_ready_o);

  // R3: configuration request held stable until acknowledged
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_ack_i) |=>
      (err_o || (cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_data_o))));

  // R3: memory request held stable until acknowledged
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (err_o || (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o))));

  // R3: an acknowledged DRAM write needs a fresh stream word first
  a_r3_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i) |=> !mem_req_o);

  // R7: release only out of remap or idle
  a_r7_release_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> ($past(status_o) == 3'd3 || $past(status_o) == 3'd0));

  // R7: once released, stays released
  a_r7_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n_o |=> cpu_rst_n_o);

  // R7: done is a single pulse during release
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cpu_rst_n_o && $rose(cpu_rst_n_o)));

  // R9: fault is sticky and quiet
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && !cpu_rst_n_o && !cfg_req_o && !mem_req_o && !img_ready_o));

endmodule

bind boot_shadow_seq bss_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_req_o(cfg_req_o), .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o),
  .cfg_ack_i(cfg_ack_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .mem_ack_i(mem_ack_i),
  .img_ready_o(img_ready_o), .cpu_rst_n_o(cpu_rst_n_o), .done_o(done_o),
  .err_o(err_o), .status_o(status_o)
);

// File: tb/sim_boot_shadow_seq.sv
`timescale 1ns/1ps
module sim_boot_shadow_seq;

  localparam logic [31:0] MAGIC = 32'hB007_1A9E;
  localparam int P_IDLE = 0, P_INIT = 1, P_MAGIC = 2, P_LEN = 3, P_COPY = 4,
                 P_REMAP = 5, P_RUN = 6, P_FAULT = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b0;
  logic        cfg_req, cfg_ack = 1'b0;
  logic [31:0] cfg_addr, cfg_data;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_data;
  logic        img_valid = 1'b0;
  logic [31:0] img_data = '0;
  logic        img_ready, cpu_rst_n, done, err;
  logic [2:0]  status;

  always #2.5 clk = ~clk;

  boot_shadow_seq u0 (
    .clk(clk), .rst_n(rst_n), .prog_mode_i(prog_mode),
    .cfg_req_o(cfg_req), .cfg_addr_o(cfg_addr), .cfg_data_o(cfg_data),
    .cfg_ack_i(cfg_ack),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ack_i(mem_ack),
    .img_valid_i(img_valid), .img_data_i(img_data), .img_ready_o(img_ready),
    .cpu_rst_n_o(cpu_rst_n), .done_o(done), .err_o(err), .status_o(status)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model state
  int          ph, idx, waitc, n, len, idle_c;
  bit          pend, rel_seen, hold;
  logic [31:0] word;
  logic [31:0] sq[$];
  logic [31:0] dram [int];
  int          n_init, n_mem, n_remap, n_done;
  int          stall_cfg, stall_mem, gap;
  bit          stall_remap;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_status(input int p);
    case (p)
      P_IDLE: return 3'd0;
      P_INIT: return 3'd1;
      P_MAGIC, P_LEN, P_COPY: return 3'd2;
      P_REMAP: return 3'd3;
      P_RUN: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    bit e_cfg, e_mem, e_rdy, took, stall;
    @(negedge clk);
    e_cfg = (ph == P_INIT) || (ph == P_REMAP);
    e_mem = (ph == P_COPY) && pend;
    e_rdy = (ph == P_MAGIC) || (ph == P_LEN) || (ph == P_COPY && !pend);
    chk(status == exp_status(ph), "R11 status", {29'd0, status}, {29'd0, exp_status(ph)});
    chk(cpu_rst_n == (ph == P_RUN), "R7 cpu reset", {31'd0, cpu_rst_n}, {31'd0, ph == P_RUN});
    chk(err == (ph == P_FAULT), "R9 err flag", {31'd0, err}, {31'd0, ph == P_FAULT});
    chk(done == (ph == P_RUN && !rel_seen), "R7 done pulse", {31'd0, done},
        {31'd0, ph == P_RUN && !rel_seen});
    chk(cfg_req == e_cfg, "R2 cfg request", {31'd0, cfg_req}, {31'd0, e_cfg});
    chk(mem_req == e_mem, "R3 mem request", {31'd0, mem_req}, {31'd0, e_mem});
    chk(img_ready == e_rdy, "R3 stream ready", {31'd0, img_ready}, {31'd0, e_rdy});
    if (cfg_req && ph == P_INIT) begin
      chk(cfg_addr == 32'h4002_0000 + 32'(8 * idx), "R2 init addr", cfg_addr,
          32'h4002_0000 + 32'(8 * idx));
      chk(cfg_data == 32'h1000_0000 + 32'(17 * idx), "R2 init data", cfg_data,
          32'h1000_0000 + 32'(17 * idx));
    end
    if (cfg_req && ph == P_REMAP) begin
      chk(cfg_addr == 32'h4003_8008, "R6 remap addr", cfg_addr, 32'h4003_8008);
      chk(cfg_data == 32'h1, "R6 remap data", cfg_data, 32'h1);
    end
    if (mem_req && e_mem) begin
      chk(mem_addr == 32'hA000_0000 + 32'(4 * n), "R4 dram addr", mem_addr,
          32'hA000_0000 + 32'(4 * n));
      chk(mem_data == word, "R4 dram data", mem_data, word);
    end
    if (done) n_done++;
    if (ph == P_RUN) rel_seen = 1'b1;

    // drive inputs for the coming edge
    cfg_ack = 1'b0;
    mem_ack = 1'b0;
    if (cfg_req) begin
      stall = (ph == P_INIT && idx == stall_cfg) || (ph == P_REMAP && stall_remap);
      cfg_ack = !stall && ($urandom_range(0, 2) != 0);
    end
    if (mem_req) begin
      stall = (n == stall_mem);
      mem_ack = !stall && ($urandom_range(0, 2) != 0);
    end
    if (!hold) begin
      if (sq.size() > 0 && $urandom_range(0, gap) == 0) begin
        img_valid = 1'b1;
        img_data  = sq[0];
      end else begin
        img_valid = 1'b0;
      end
    end
    took = img_valid && e_rdy;

    // model update
    case (ph)
      P_IDLE: begin
        idle_c++;
        if (idle_c == 2) ph = prog_mode ? P_RUN : P_INIT;
      end
      P_INIT: begin
        if (cfg_ack) begin
          n_init++; idx++; waitc = 0;
          if (idx == 8) ph = P_MAGIC;
        end else begin
          waitc++;
          if (waitc == 1024) ph = P_FAULT;
        end
      end
      P_MAGIC: if (img_valid) ph = (img_data == MAGIC) ? P_LEN : P_FAULT;
      P_LEN: if (img_valid) begin
        len = int'(img_data); n = 0;
        ph = (len == 0) ? P_REMAP : P_COPY;
      end
      P_COPY: begin
        if (!pend) begin
          if (img_valid) begin pend = 1'b1; word = img_data; end
        end else if (mem_ack) begin
          dram[4 * n] = word; n_mem++; n++; pend = 1'b0; waitc = 0;
          if (n == len) ph = P_REMAP;
        end else begin
          waitc++;
          if (waitc == 1024) ph = P_FAULT;
        end
      end
      P_REMAP: begin
        if (cfg_ack) begin n_remap++; waitc = 0; ph = P_RUN; end
        else begin
          waitc++;
          if (waitc == 1024) ph = P_FAULT;
        end
      end
      default: ;
    endcase
    if (took) begin
      void'(sq.pop_front());
      hold = 1'b0;
    end else begin
      hold = img_valid;
    end
  endtask

  task automatic start_case(input bit prog, input logic [31:0] hdr, input int plen,
                            input int g, input int sc, input int sm, input bit sr);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_ack = 1'b0; mem_ack = 1'b0; img_valid = 1'b0;
    prog_mode = prog;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(!cpu_rst_n && status == 3'd0 && !done && !err && !cfg_req && !mem_req && !img_ready,
        "R1 reset state", {24'd0, cpu_rst_n, status, done, err, cfg_req, mem_req, img_ready},
        32'd0);
    ph = P_IDLE; idx = 0; waitc = 0; n = 0; len = 0; idle_c = 0;
    pend = 0; rel_seen = 0; hold = 0; word = '0;
    n_init = 0; n_mem = 0; n_remap = 0; n_done = 0;
    dram.delete();
    sq.delete();
    gap = g; stall_cfg = sc; stall_mem = sm; stall_remap = sr;
    sq.push_back(hdr);
    sq.push_back(32'(plen));
    for (int k = 0; k < plen; k++) sq.push_back(32'h2000_0000 + 32'(k * 32'h0001_3579));
    rst_n = 1'b1;
  endtask

  task automatic run_out(input int extra);
    for (int k = 0; k < 6000 && !(ph == P_RUN || ph == P_FAULT); k++) step();
    repeat (extra) step();
  endtask

  initial begin
    // case 1: short image, stream gaps
    start_case(0, MAGIC, 6, 1, -1, -1, 0);
    run_out(10);
    chk(cpu_rst_n, "R7 released after boot", {31'd0, cpu_rst_n}, 32'd1);
    chk(n_init == 8, "R2 init count", 32'(n_init), 32'd8);
    chk(n_mem == 6, "R4 payload count", 32'(n_mem), 32'd6);
    chk(n_remap == 1, "R6 one remap", 32'(n_remap), 32'd1);
    chk(n_done == 1, "R7 single done", 32'(n_done), 32'd1);
    chk(dram.exists(0) && dram[0] == 32'h2000_0000, "R5 stack pointer at 0",
        dram.exists(0) ? dram[0] : 32'hx, 32'h2000_0000);
    chk(dram.exists(4) && dram[4] == 32'h2001_3579, "R5 reset handler at 4",
        dram.exists(4) ? dram[4] : 32'hx, 32'h2001_3579);

    // case 2: programming mode
    start_case(1, MAGIC, 4, 0, -1, -1, 0);
    run_out(10);
    chk(cpu_rst_n && n_init == 0 && n_mem == 0 && n_remap == 0, "R8 prog mode bypass",
        32'(n_init + n_mem + n_remap), 32'd0);
    chk(sq.size() == 6, "R8 stream untouched", 32'(sq.size()), 32'd6);
    chk(n_done == 1, "R7 done in prog mode", 32'(n_done), 32'd1);

    // case 3: bad header, then keep driving
    start_case(0, 32'hDEAD_BEEF, 4, 0, -1, -1, 0);
    run_out(60);
    chk(err && !cpu_rst_n, "R9 bad magic fault", {30'd0, err, cpu_rst_n}, 32'd2);
    chk(n_mem == 0 && n_remap == 0, "R9 no copy or remap", 32'(n_mem + n_remap), 32'd0);

    // case 4: empty payload
    start_case(0, MAGIC, 0, 0, -1, -1, 0);
    run_out(8);
    chk(cpu_rst_n && n_mem == 0 && n_remap == 1, "R5 zero length", 32'(n_mem), 32'd0);

    // case 5: init acknowledge withheld
    start_case(0, MAGIC, 3, 0, 3, -1, 0);
    run_out(20);
    chk(err && n_init == 3, "R10 init timeout", 32'(n_init), 32'd3);

    // case 6: dram acknowledge withheld
    start_case(0, MAGIC, 5, 0, -1, 2, 0);
    run_out(20);
    chk(err && n_mem == 2 && n_remap == 0, "R10 copy timeout", 32'(n_mem), 32'd2);

    // case 7: long image, heavy stream gaps
    start_case(0, MAGIC, 40, 3, -1, -1, 0);
    run_out(8);
    chk(cpu_rst_n && n_mem == 40, "R4 long image count", 32'(n_mem), 32'd40);
    chk(dram.exists(156) && dram[156] == 32'h2000_0000 + 32'(39 * 32'h0001_3579),
        "R4 last payload word", dram.exists(156) ? dram[156] : 32'hx,
        32'h2000_0000 + 32'(39 * 32'h0001_3579));

    // case 8: remap acknowledge withheld
    start_case(0, MAGIC, 2, 0, -1, -1, 1);
    run_out(20);
    chk(err && !cpu_rst_n && n_remap == 0, "R10 remap timeout", 32'(n_remap), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule